// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is a behavioural, synthesizable model of a true dual-port memory in which two independent ports share one storage array. Each port has its own rising-edge clock, clock enable, write enable, 13-bit address, write data and a registered read output. At elaboration time each port picks a data width of 1, 2, 4 or 9 bits. The array is organised as 1024 rows of 9 bits, so a narrow port and a wide port see the same bits through different windows.

Each port also picks, by parameter, what its read register shows in a write cycle: it keeps its previous value, it passes the write data through, or it returns the prior contents of the addressed location. A shared clear-mode parameter sets whether the active-low read-clear inputs act on the next clock edge or at once. The power-up contents of the array come from a parameter vector. The read registers always start at zero.

Top module: `mixwidth_tdpram`

## Requirements
- R1: Both read outputs are zero from power-up until the first clock edge on which their port updates, whatever the array holds.
- R2: A port of width w addresses row addr[12:3]. At width 9 the port covers the whole 9-bit row and ignores addr[2:0]. At width 1, 2 or 4 it covers bits [off+w-1:off] of the row, where off is addr[2:0] with its low log2(w) bits cleared. Bit 8 of a row is reachable only through a 9-bit port.
- R3: On a rising edge with enable high, clear inactive and write low, the read output takes the addressed word and holds it until the next update.
- R4: On an edge with enable low, the port neither writes the array nor changes its read output.
- R5: In mode WR_KEEP (code 0), a write cycle leaves the port's read output unchanged.
- R6: In mode WR_PASS (code 1), a write cycle loads the port's write data into its read output.
- R7: In mode WR_PRIOR (code 2), a write cycle loads the value the addressed location held before that write.
- R8: With clear mode CLR_SYNC (code 0), a low clear input zeroes the read output on the next edge whether the enable is high or low, and it overrides any write-mode update. A write enabled in the same cycle still reaches the array. Before that edge the output holds.
- R9: With clear mode CLR_ASYNC (code 1), a low clear input zeroes the read output at once, without a clock edge.
- R10: Bit r*9+b of the INIT parameter is the power-up value of bit b of row r.
- R11: A read on one port in the same cycle that the other port writes the same row returns the contents from before that write. The write shows on the following read. Two writes to the same bits in one cycle leave those bits undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock, rising edge |
| en_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| rst_a_n | input | 1 | Port A read-output clear, active low |
| addr_a | input | ADDR_W | Port A address |
| wdata_a | input | WIDTH_A | Port A write data |
| rdata_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| en_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| rst_b_n | input | 1 | Port B read-output clear, active low |
| addr_b | input | ADDR_W | Port B address |
| wdata_b | input | WIDTH_B | Port B write data |
| rdata_b | output | WIDTH_B | Port B registered read data |

## Verification
On every cycle, the assertions check that a disabled port's read register holds, that a write cycle follows the port's configured mode (hold, pass-through or prior contents), that a plain read returns the addressed slice one edge later, and that every write mask covers exactly the port's width. Other behaviours can only be shown by the bench's scenarios. These are how narrow and wide windows overlap in one row, the power-up contents taken from the parameter, the immediate clear against the edge-timed clear, a write that still lands while the read register is held clear, and the prior-value result of a read that collides with a write from the other port.

// File: rtl/tdpram_pkg.sv
// Shared constants and mode encodings for the mixed-width dual-port RAM.
// Assumes a 9-bit physical row with 3 sub-row address bits.
package tdpram_pkg;
    localparam int WORD_W = 9;   // bits per physical row
    localparam int SUB_W  = 3;   // address bits that select inside a row

    // Read-register behaviour during a write cycle
    typedef enum logic [1:0] {
        WR_KEEP  = 2'd0,
        WR_PASS  = 2'd1,
        WR_PRIOR = 2'd2
    } wr_mode_e;

    // Timing of the read-register clear
    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/tdpram_bank.sv
// One storage bank: a single write port on its own clock and two
// combinational read ports. The RAM keeps two banks, one written by each
// port. The logical contents are the XOR of the two banks.
// Assumes the caller supplies a bit mask and already XOR-encoded data.
module tdpram_bank
    import tdpram_pkg::*;
#(
    parameter int ROW_AW = 10,
    parameter bit LOAD_INIT = 1'b0,
    parameter logic [(2**ROW_AW)*WORD_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ROW_AW-1:0] rd_row_0,
    input  logic [ROW_AW-1:0] rd_row_1,
    output logic [WORD_W-1:0] rd_word_0,
    output logic [WORD_W-1:0] rd_word_1
);
    localparam int ROWS = 2**ROW_AW;

    logic [WORD_W-1:0] mem [ROWS];

    // Power-up contents: the parameter image, or all zeros for the partner bank
    initial begin
        for (int r = 0; r < ROWS; r++) begin
            mem[r] = LOAD_INIT ? INIT[r*WORD_W +: WORD_W] : '0;
        end
    end

    // Masked write of the selected bits of one row
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= (mem[wr_row] & ~wr_mask) | (wr_word & wr_mask);
        end
    end

    assign rd_word_0 = mem[rd_row_0];
    assign rd_word_1 = mem[rd_row_1];
endmodule

// File: rtl/tdpram_port.sv
// One access port: splits the address into row and lane, builds the write
// mask and the XOR-encoded write word, selects the read slice and keeps
// the registered read output with its write mode and clear mode.
// Assumes WIDTH is 1, 2, 4 or 9, and that own_word/other_word are both
// banks read at this port's row.
module tdpram_port
    import tdpram_pkg::*;
#(
    parameter int        ADDR_W = 13,
    parameter int        WIDTH  = 9,
    parameter wr_mode_e  WMODE  = WR_KEEP,
    parameter clr_mode_e CMODE  = CLR_SYNC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [WORD_W-1:0]         own_word,
    input  logic [WORD_W-1:0]         other_word,
    output logic [ADDR_W-SUB_W-1:0]   row,
    output logic                      bank_we,
    output logic [WORD_W-1:0]         bank_mask,
    output logic [WORD_W-1:0]         bank_word,
    output logic [WIDTH-1:0]          rdata
);
    localparam bit FULL = (WIDTH == WORD_W);

    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] lane_data;
    logic [WIDTH-1:0]  cur_slice;
    logic [WIDTH-1:0]  q_nxt;
    logic [WIDTH-1:0]  q_r = '0;

    assign row      = addr[ADDR_W-1:SUB_W];
    assign cur_word = own_word ^ other_word;

    // Lane selection: a full-width port owns the row, a narrow one a slice
    generate
        if (FULL) begin : g_full
            logic [SUB_W-1:0] unused_low;
            assign unused_low = addr[SUB_W-1:0];
            assign lane_mask  = '1;
            assign lane_data  = WORD_W'(wdata);
            assign cur_slice  = WIDTH'(cur_word);
        end else begin : g_narrow
            localparam logic [SUB_W-1:0]  ALIGN     = ~SUB_W'(WIDTH - 1);
            localparam logic [WORD_W-1:0] BASE_MASK = WORD_W'((1 << WIDTH) - 1);
            logic [SUB_W-1:0] bit_off;
            assign bit_off   = addr[SUB_W-1:0] & ALIGN;
            assign lane_mask = BASE_MASK << bit_off;
            assign lane_data = WORD_W'(wdata) << bit_off;
            assign cur_slice = WIDTH'(cur_word >> bit_off);
        end
    endgenerate

    assign bank_we   = en & we;
    assign bank_mask = lane_mask;
    assign bank_word = lane_data ^ other_word;

    // Next read value: plain read, or the write-mode choice in a write cycle
    always_comb begin
        q_nxt = cur_slice;
        if (we) begin
            case (WMODE)
                WR_KEEP: q_nxt = q_r;
                WR_PASS: q_nxt = wdata;
                default: q_nxt = cur_slice;
            endcase
        end
    end

    // Read register, cleared on an edge or at once depending on CMODE
    generate
        if (CMODE == CLR_SYNC) begin : g_sync_clr
            always_ff @(posedge clk) begin
                if (!rst_n)  q_r <= '0;
                else if (en) q_r <= q_nxt;
            end
        end else begin : g_async_clr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  q_r <= '0;
                else if (en) q_r <= q_nxt;
            end
        end
    endgenerate

    assign rdata = q_r;

    // R4: a disabled port keeps its read output
    assert_en_low_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q_r));

    // R3: a plain read shows the addressed slice one edge later
    assert_read_slice_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> (q_r == $past(cur_slice)));

    // R2: every write touches exactly WIDTH bits of the row
    assert_lane_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> ($countones(bank_mask) == WIDTH));

    generate
        if (WMODE == WR_KEEP) begin : g_chk_keep
            // R5: hold the read output in a write cycle
            assert_keep_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> $stable(q_r));
        end else if (WMODE == WR_PASS) begin : g_chk_pass
            // R6: the written data appears on the read output
            assert_pass_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (q_r == $past(wdata)));
        end else begin : g_chk_prior
            // R7: the prior contents appear on the read output
            assert_prior_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (q_r == $past(cur_slice)));
        end
    endgenerate
endmodule

// File: rtl/mixwidth_tdpram.sv
// Mixed-width true dual-port RAM. Two ports of independent width share
// 2**(ADDR_W-3) rows of 9 bits. Each port writes only its own bank, and
// a read XORs both banks, so the two write clocks never drive the same storage.
// Assumes WIDTH_A and WIDTH_B are each 1, 2, 4 or 9, and that the two ports
// never write the same bits in the same cycle.
module mixwidth_tdpram
    import tdpram_pkg::*;
#(
    parameter int        ADDR_W   = 13,
    parameter int        WIDTH_A  = 9,
    parameter int        WIDTH_B  = 9,
    parameter wr_mode_e  WMODE_A  = WR_KEEP,
    parameter wr_mode_e  WMODE_B  = WR_KEEP,
    parameter clr_mode_e CLR_MODE = CLR_SYNC,
    parameter logic [(2**(ADDR_W-SUB_W))*WORD_W-1:0] INIT = '0
) (
    input  logic               clk_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic               rst_a_n,
    input  logic [ADDR_W-1:0]  addr_a,
    input  logic [WIDTH_A-1:0] wdata_a,
    output logic [WIDTH_A-1:0] rdata_a,
    input  logic               clk_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic               rst_b_n,
    input  logic [ADDR_W-1:0]  addr_b,
    input  logic [WIDTH_B-1:0] wdata_b,
    output logic [WIDTH_B-1:0] rdata_b
);
    localparam int ROW_AW = ADDR_W - SUB_W;

    logic [ROW_AW-1:0] row_a, row_b;
    logic              bwe_a, bwe_b;
    logic [WORD_W-1:0] mask_a, mask_b;
    logic [WORD_W-1:0] word_a, word_b;
    logic [WORD_W-1:0] bank_a_at_a, bank_a_at_b;
    logic [WORD_W-1:0] bank_b_at_a, bank_b_at_b;

    // Bank written by port A, holding the power-up image
    tdpram_bank #(
        .ROW_AW(ROW_AW), .LOAD_INIT(1'b1), .INIT(INIT)
    ) u_bank_a (
        .clk(clk_a), .wr_en(bwe_a), .wr_row(row_a), .wr_mask(mask_a),
        .wr_word(word_a), .rd_row_0(row_a), .rd_row_1(row_b),
        .rd_word_0(bank_a_at_a), .rd_word_1(bank_a_at_b)
    );

    // Bank written by port B, starting at zero
    tdpram_bank #(
        .ROW_AW(ROW_AW), .LOAD_INIT(1'b0), .INIT('0)
    ) u_bank_b (
        .clk(clk_b), .wr_en(bwe_b), .wr_row(row_b), .wr_mask(mask_b),
        .wr_word(word_b), .rd_row_0(row_a), .rd_row_1(row_b),
        .rd_word_0(bank_b_at_a), .rd_word_1(bank_b_at_b)
    );

    tdpram_port #(
        .ADDR_W(ADDR_W), .WIDTH(WIDTH_A), .WMODE(WMODE_A), .CMODE(CLR_MODE)
    ) u_port_a (
        .clk(clk_a), .rst_n(rst_a_n), .en(en_a), .we(we_a), .addr(addr_a),
        .wdata(wdata_a), .own_word(bank_a_at_a), .other_word(bank_b_at_a),
        .row(row_a), .bank_we(bwe_a), .bank_mask(mask_a), .bank_word(word_a),
        .rdata(rdata_a)
    );

    tdpram_port #(
        .ADDR_W(ADDR_W), .WIDTH(WIDTH_B), .WMODE(WMODE_B), .CMODE(CLR_MODE)
    ) u_port_b (
        .clk(clk_b), .rst_n(rst_b_n), .en(en_b), .we(we_b), .addr(addr_b),
        .wdata(wdata_b), .own_word(bank_b_at_b), .other_word(bank_a_at_b),
        .row(row_b), .bank_we(bwe_b), .bank_mask(mask_b), .bank_word(word_b),
        .rdata(rdata_b)
    );
endmodule

// File: tb/mixwidth_tdpram_tb.sv
`timescale 1ns/1ps
module mixwidth_tdpram_tb;
    import tdpram_pkg::*;

    localparam int ROWS = 1024;
    localparam int IB   = ROWS * 9;
    localparam logic [IB-1:0] TB_INIT = {128{72'h5A3C96E1F0D2B4877C}};

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        en_a, we_a, rst_a_n, en_b, we_b, rst_b_n;
    logic [12:0] addr_a, addr_b;
    logic [8:0]  wd_a, wd_b;
    logic [8:0]  q0a;
    logic [1:0]  q0b;
    logic [3:0]  q1a;
    logic [0:0]  q1b;

    // Main configuration: A 9-bit pass-through, B 2-bit prior value, edge clear
    mixwidth_tdpram #(
        .ADDR_W(13), .WIDTH_A(9), .WIDTH_B(2), .WMODE_A(WR_PASS),
        .WMODE_B(WR_PRIOR), .CLR_MODE(CLR_SYNC), .INIT(TB_INIT)
    ) u_dut (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a_n(rst_a_n), .addr_a(addr_a),
        .wdata_a(wd_a), .rdata_a(q0a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b_n(rst_b_n), .addr_b(addr_b),
        .wdata_b(wd_b[1:0]), .rdata_b(q0b)
    );

    // Second configuration: A 4-bit keep, B 1-bit prior value, immediate clear
    mixwidth_tdpram #(
        .ADDR_W(13), .WIDTH_A(4), .WIDTH_B(1), .WMODE_A(WR_KEEP),
        .WMODE_B(WR_PRIOR), .CLR_MODE(CLR_ASYNC), .INIT(TB_INIT)
    ) u_dut_alt (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a_n(rst_a_n), .addr_a(addr_a),
        .wdata_a(wd_a[3:0]), .rdata_a(q1a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b_n(rst_b_n), .addr_b(addr_b),
        .wdata_b(wd_b[0:0]), .rdata_b(q1b)
    );

    logic [8:0] refm [2][ROWS];
    logic [8:0] expq [2][2];
    int         wid  [2][2];
    wr_mode_e   md   [2][2];
    int nchk = 0;
    int nfail = 0;

    function automatic logic [8:0] msk(int w);
        return (9'(1) << w) - 9'd1;
    endfunction

    function automatic int offs(int w, logic [12:0] a);
        return (w == 9) ? 0 : (int'(a[2:0]) / w) * w;
    endfunction

    function automatic logic [8:0] ref_rd(int d, int w, logic [12:0] a);
        return (refm[d][a[12:3]] >> offs(w, a)) & msk(w);
    endfunction

    task automatic ref_wr(int d, int w, logic [12:0] a, logic [8:0] v);
        logic [8:0] m;
        m = msk(w) << offs(w, a);
        refm[d][a[12:3]] = (refm[d][a[12:3]] & ~m) | (((v & msk(w)) << offs(w, a)) & m);
    endtask

    function automatic logic [8:0] got(int d, int p);
        if (d == 0) return (p == 0) ? q0a : {7'b0, q0b};
        return (p == 0) ? {5'b0, q1a} : {8'b0, q1b};
    endfunction

    task automatic check(string tag, int d, int p, logic [8:0] act, logic [8:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s dut%0d port%0d actual %h expected %h", tag, d, p, act, exp);
        end
    endtask

    task automatic drv_a(logic e, logic w, int a, logic [8:0] v);
        en_a = e; we_a = w; addr_a = 13'(a); wd_a = v;
    endtask

    task automatic drv_b(logic e, logic w, int a, logic [8:0] v);
        en_b = e; we_b = w; addr_b = 13'(a); wd_b = v;
    endtask

    // One clock: predict outputs, update the model, then compare after the edge
    task automatic cyc(string tg_ovr);
        logic [8:0] ne [2][2];
        string      tg [2][2];
        logic e, w, r;
        logic [12:0] a;
        logic [8:0] v;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                e = p ? en_b : en_a; w = p ? we_b : we_a; r = p ? rst_b_n : rst_a_n;
                a = p ? addr_b : addr_a; v = p ? wd_b : wd_a;
                if (!r) begin
                    ne[d][p] = '0; tg[d][p] = "R8";
                end else if (!e) begin
                    ne[d][p] = expq[d][p]; tg[d][p] = "R4";
                end else if (w) begin
                    case (md[d][p])
                        WR_KEEP: begin ne[d][p] = expq[d][p]; tg[d][p] = "R5"; end
                        WR_PASS: begin ne[d][p] = v & msk(wid[d][p]); tg[d][p] = "R6"; end
                        default: begin ne[d][p] = ref_rd(d, wid[d][p], a); tg[d][p] = "R7"; end
                    endcase
                end else begin
                    ne[d][p] = ref_rd(d, wid[d][p], a); tg[d][p] = "R3";
                end
                if (tg_ovr != "") tg[d][p] = tg_ovr;
            end
        end
        for (int d = 0; d < 2; d++) begin
            if (en_a && we_a) ref_wr(d, wid[d][0], addr_a, wd_a);
            if (en_b && we_b) ref_wr(d, wid[d][1], addr_b, wd_b);
        end
        @(posedge clk);
        #1;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                expq[d][p] = ne[d][p];
                check(tg[d][p], d, p, got(d, p), ne[d][p]);
            end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        wid[0][0] = 9; wid[0][1] = 2; wid[1][0] = 4; wid[1][1] = 1;
        md[0][0] = WR_PASS; md[0][1] = WR_PRIOR; md[1][0] = WR_KEEP; md[1][1] = WR_PRIOR;
        for (int r = 0; r < ROWS; r++) begin
            refm[0][r] = TB_INIT[r*9 +: 9];
            refm[1][r] = TB_INIT[r*9 +: 9];
        end
        for (int d = 0; d < 2; d++) for (int p = 0; p < 2; p++) expq[d][p] = '0;
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        drv_a(0, 0, 0, 0); drv_b(0, 0, 0, 0);

        // R1: read outputs are zero before any clock edge
        #1;
        for (int d = 0; d < 2; d++) for (int p = 0; p < 2; p++) check("R1", d, p, got(d, p), 9'h0);
        cyc("R1");

        // R8: edge-timed clear with enable low
        rst_a_n = 1'b0; rst_b_n = 1'b0;
        cyc("R8"); cyc("R8");
        rst_a_n = 1'b1; rst_b_n = 1'b1;

        // R10: untouched rows show the parameter image
        for (int k = 0; k < 4; k++) begin
            drv_a(1, 0, 8*(k+3) + k, 0);
            drv_b(1, 0, 8*(k+100) + 2*k, 0);
            cyc("R10");
        end

        // R2: narrow and wide windows onto the same rows
        drv_b(1, 1, 8*40+6, 9'h002); drv_a(1, 0, 8*40+5, 0); cyc("R2");
        drv_b(1, 0, 8*40+7, 0);      drv_a(1, 0, 8*40+3, 0); cyc("R2");
        drv_b(1, 0, 8*40+6, 0);      drv_a(1, 0, 8*40+4, 0); cyc("R2");
        drv_a(1, 1, 8*41+7, 9'h155); drv_b(0, 0, 0, 0);      cyc("R2");
        drv_a(0, 0, 0, 0);           drv_b(1, 0, 8*41+2, 0); cyc("R2");
        drv_b(1, 0, 8*41+5, 0);                              cyc("R2");

        // R11: a read colliding with the other port's write sees old data
        drv_a(1, 1, 8*50+1, 9'h0F0); drv_b(1, 0, 8*50+4, 0); cyc("R11");
        drv_a(1, 0, 8*50, 0);        drv_b(1, 0, 8*50+4, 0); cyc("R11");
        drv_b(1, 1, 8*51+2, 9'h003); drv_a(1, 0, 8*51, 0);   cyc("R11");
        drv_b(0, 0, 0, 0);                                   cyc("R11");

        // R4: a write with enable low changes neither array nor output
        drv_a(0, 1, 8*61, 9'h1AB); drv_b(0, 1, 8*62, 9'h003); cyc("R4");
        drv_a(1, 0, 8*61, 0);      drv_b(1, 0, 8*62, 0);      cyc("R4");

        // Fill the outputs with ones, then contrast the two clear modes
        drv_a(1, 1, 8*9, 9'h1FF); drv_b(1, 1, 8*20, 9'h1FF); cyc("");
        drv_a(1, 0, 8*9, 0);      drv_b(1, 0, 8*20, 0);      cyc("R3");
        rst_a_n = 1'b0; rst_b_n = 1'b0;
        #1;
        check("R9", 1, 0, got(1, 0), 9'h0);
        check("R9", 1, 1, got(1, 1), 9'h0);
        check("R8", 0, 0, got(0, 0), expq[0][0]);
        check("R8", 0, 1, got(0, 1), expq[0][1]);
        expq[1][0] = '0; expq[1][1] = '0;
        drv_a(0, 0, 0, 0); drv_b(0, 0, 0, 0); cyc("R8");

        // R8: a write during the clear still lands in the array
        drv_a(1, 1, 8*60, 9'h0AB); drv_b(1, 1, 8*70+1, 9'h001); cyc("R8");
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        drv_a(1, 0, 8*60, 0);      drv_b(1, 0, 8*70+1, 0);      cyc("R8");

        // R5, R6, R7: directed write cycles in every mode
        drv_a(1, 1, 8*80+4, 9'h16D); drv_b(1, 1, 8*81+2, 9'h002); cyc("");
        drv_a(1, 1, 8*82+1, 9'h0B2); drv_b(1, 1, 8*83+6, 9'h001); cyc("");

        // Random mix of reads, writes, idle cycles and clears
        for (int n = 0; n < 3000; n++) begin
            int ra, rb;
            rst_a_n = ($urandom % 32) != 0;
            rst_b_n = ($urandom % 32) != 0;
            ra = (($urandom % 4) == 0) ? int'($urandom % ROWS) : int'($urandom % 8);
            rb = (($urandom % 4) == 0) ? int'($urandom % ROWS) : int'($urandom % 8);
            drv_a(($urandom % 8) != 0, $urandom % 2, ra*8 + int'($urandom % 8), 9'($urandom));
            drv_b(($urandom % 8) != 0, $urandom % 2, rb*8 + int'($urandom % 8), 9'($urandom));
            if (en_a && we_a && en_b && we_b && (addr_a[12:3] == addr_b[12:3])) we_b = 1'b0;
            cyc("");
        end

        summary();
        $finish;
    end
endmodule